// File: doc/BRIEF.md
# GPIO Interrupt Event Detector

This block watches every input pin of one general-purpose I/O bank and turns selected pin activity into latched events. Each pin can be armed to sense a low level, a high level, a rising edge and a falling edge, in any combination. A sensed event sets that pin's bit in a status word. Software clears a status bit by writing a one to it. An interrupt-enable mask selects which latched events drive the single bank interrupt line. A separate wake-enable mask lets edge events raise a wake request.

Software reaches the block through a plain synchronous register port: address, write data and a write strobe, with read data registered one clock after the address. The interrupt-enable word can be loaded whole, or changed bit by bit through a set address and a clear address. A pin-direction word is also held here and resets to all inputs. The pin inputs are asynchronous and pass through a two-flop synchroniser before any detection. There is no streaming data path, so every pin is a plain control or status signal.

Top module: `gpio_evt_detect`

## Requirements
- R1: Each pin has four sense enables that may be combined: low level (address 5), high level (address 6), rising edge (address 7) and falling edge (address 8), one bit per pin at the pin's index. A pin with both edge enables set latches an event on each transition.
- R2: Writing the status word (address 0) clears every bit written as one; bits written as zero keep their value.
- R3: The interrupt-enable word is loaded whole at address 1, gains the written ones at address 2 and loses the written ones at address 3; the set and clear addresses leave the other bits unchanged. Reads of addresses 1, 2 and 3 return the enable word.
- R4: `irq_o` is high exactly when some status bit and its interrupt-enable bit are both one.
- R5: A level-sensed status bit is set again at once after a clear while its pin stays at the sensed level; the clear only sticks once the pin has left that level.
- R6: `wake_o` is raised only by an edge event on a pin whose wake-enable bit (address 4) is one; level events never raise it. It stays high until the status bit of that pin is cleared.
- R7: After reset the status word and the interrupt-enable word are zero, the direction word (address 9) is all ones, and `irq_o` and `wake_o` are low.
- R8: A pin change applied before clock edge k sets its status bit at edge k+2 (two synchroniser flops, then the event register).
- R9: When a status clear and a new edge event hit the same bit in the same cycle, the bit ends up set.
- R10: Every register written at addresses 1 and 4 to 9 reads back the written value one clock after its address is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_i | input | NPINS | Asynchronous pin levels |
| addr_i | input | 4 | Register address |
| wdata_i | input | NPINS | Write data |
| we_i | input | 1 | Write strobe |
| rdata_o | output | NPINS | Read data, registered from `addr_i` |
| irq_o | output | 1 | Bank interrupt |
| wake_o | output | 1 | Wake request |

## Verification
Every pin is tried alone in each of the four sense modes, driving the level that should match into a pin that was held at the opposite level, which separates a swapped sense bit, a wrong pin index and a level detector answering to an edge. Rising and falling together, a half-word clear and the set and clear enable addresses with mixed patterns tell combined enables from overwriting ones. A level pin held active across a clear, a clear that lands in the same cycle as a fresh edge, and a mix of level and edge pins under wake enable show the re-set, the priority rule and the edge-only wake. One pin change sampled two and three clocks later pins down the synchroniser latency.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    REG_STATUS     = 4'd0,
    REG_IEN        = 4'd1,
    REG_IEN_SET    = 4'd2,
    REG_IEN_CLR    = 4'd3,
    REG_WAKE_EN    = 4'd4,
    REG_SENSE_LOW  = 4'd5,
    REG_SENSE_HIGH = 4'd6,
    REG_SENSE_RISE = 4'd7,
    REG_SENSE_FALL = 4'd8,
    REG_DIR        = 4'd9
  } reg_sel_e;
endpackage

// File: rtl/gpio_evt_sync.sv
module gpio_evt_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [STAGES-1:0][W-1:0] chain_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q[s] <= '0;
        else        chain_q[s] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q[s] <= '0;
        else        chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_evt_edge.sv
module gpio_evt_edge #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] sense_low_i,
  input  logic [W-1:0] sense_high_i,
  input  logic [W-1:0] sense_rise_i,
  input  logic [W-1:0] sense_fall_i,
  output logic [W-1:0] evt_o,
  output logic [W-1:0] edge_evt_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] rose, fell, lvl_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl_i;
  end

  always_comb begin
    rose       = lvl_i & ~prev_q;
    fell       = ~lvl_i & prev_q;
    lvl_hit    = (sense_low_i & ~lvl_i) | (sense_high_i & lvl_i);
    edge_evt_o = (sense_rise_i & rose) | (sense_fall_i & fell);
    evt_o      = lvl_hit | edge_evt_o;
  end
endmodule

// File: rtl/gpio_evt_status.sv
module gpio_evt_status #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] edge_evt_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] wake_en_i,
  output logic [W-1:0] status_o,
  output logic [W-1:0] wake_pend_o
);
  logic [W-1:0] status_d, wake_d;

  always_comb begin
    status_d = (status_o & ~clr_i) | evt_i;
    wake_d   = (wake_pend_o & ~clr_i) | (edge_evt_i & wake_en_i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_o    <= '0;
      wake_pend_o <= '0;
    end else begin
      status_o    <= status_d;
      wake_pend_o <= wake_d;
    end
  end
endmodule

// File: rtl/gpio_evt_regs.sv
module gpio_evt_regs
  import gpio_evt_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  input  logic              we_i,
  input  logic [W-1:0]      status_i,
  output logic [W-1:0]      clr_o,
  output logic [W-1:0]      ien_o,
  output logic [W-1:0]      wake_en_o,
  output logic [W-1:0]      sense_low_o,
  output logic [W-1:0]      sense_high_o,
  output logic [W-1:0]      sense_rise_o,
  output logic [W-1:0]      sense_fall_o,
  output logic [W-1:0]      dir_o,
  output logic [W-1:0]      rdata_o
);
  reg_sel_e     sel;
  logic [W-1:0] ien_d, rd_d;

  assign sel   = reg_sel_e'(addr_i);
  assign clr_o = (we_i && sel == REG_STATUS) ? wdata_i : '0;

  always_comb begin
    ien_d = ien_o;
    if (we_i) begin
      case (sel)
        REG_IEN:     ien_d = wdata_i;
        REG_IEN_SET: ien_d = ien_o | wdata_i;
        REG_IEN_CLR: ien_d = ien_o & ~wdata_i;
        default:     ien_d = ien_o;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ien_o        <= '0;
      wake_en_o    <= '0;
      sense_low_o  <= '0;
      sense_high_o <= '0;
      sense_rise_o <= '0;
      sense_fall_o <= '0;
      dir_o        <= '1;
    end else begin
      ien_o <= ien_d;
      if (we_i) begin
        case (sel)
          REG_WAKE_EN:    wake_en_o    <= wdata_i;
          REG_SENSE_LOW:  sense_low_o  <= wdata_i;
          REG_SENSE_HIGH: sense_high_o <= wdata_i;
          REG_SENSE_RISE: sense_rise_o <= wdata_i;
          REG_SENSE_FALL: sense_fall_o <= wdata_i;
          REG_DIR:        dir_o        <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (sel)
      REG_STATUS:     rd_d = status_i;
      REG_IEN,
      REG_IEN_SET,
      REG_IEN_CLR:    rd_d = ien_o;
      REG_WAKE_EN:    rd_d = wake_en_o;
      REG_SENSE_LOW:  rd_d = sense_low_o;
      REG_SENSE_HIGH: rd_d = sense_high_o;
      REG_SENSE_RISE: rd_d = sense_rise_o;
      REG_SENSE_FALL: rd_d = sense_fall_o;
      REG_DIR:        rd_d = dir_o;
      default:        rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata_o <= '0;
    else        rdata_o <= rd_d;
  end
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
  import gpio_evt_pkg::*;
#(
  parameter int NPINS     = 32,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pin_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NPINS-1:0]  wdata_i,
  input  logic              we_i,
  output logic [NPINS-1:0]  rdata_o,
  output logic              irq_o,
  output logic              wake_o
);
  logic [NPINS-1:0] pin_sync, evt, edge_evt, clr, status_q, wake_pend;
  logic [NPINS-1:0] ien, wake_en, s_low, s_high, s_rise, s_fall, dir;

  gpio_evt_sync #(.W(NPINS), .STAGES(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(pin_i), .sync_o(pin_sync)
  );

  gpio_evt_edge #(.W(NPINS)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(pin_sync),
    .sense_low_i(s_low), .sense_high_i(s_high),
    .sense_rise_i(s_rise), .sense_fall_i(s_fall),
    .evt_o(evt), .edge_evt_o(edge_evt)
  );

  gpio_evt_status #(.W(NPINS)) u_status (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .edge_evt_i(edge_evt),
    .clr_i(clr), .wake_en_i(wake_en),
    .status_o(status_q), .wake_pend_o(wake_pend)
  );

  gpio_evt_regs #(.W(NPINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wdata_i(wdata_i),
    .we_i(we_i), .status_i(status_q), .clr_o(clr), .ien_o(ien),
    .wake_en_o(wake_en), .sense_low_o(s_low), .sense_high_o(s_high),
    .sense_rise_o(s_rise), .sense_fall_o(s_fall), .dir_o(dir),
    .rdata_o(rdata_o)
  );

  assign irq_o  = |(status_q & ien);
  assign wake_o = |wake_pend;
endmodule

// File: rtl/gpio_evt_chk.sv
module gpio_evt_chk
  import gpio_evt_pkg::*;
#(
  parameter int NPINS = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_i,
  input logic [NPINS-1:0]  wdata_i,
  input logic              we_i,
  input logic [NPINS-1:0]  status_q,
  input logic [NPINS-1:0]  ien,
  input logic [NPINS-1:0]  wake_en,
  input logic [NPINS-1:0]  edge_evt,
  input logic              irq_o,
  input logic              wake_o
);
  AST_STATUS_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && addr_i == REG_STATUS) |=> ((($past(status_q) & ~$past(wdata_i)) & ~status_q) == '0)); // R2

  AST_IEN_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && addr_i == REG_IEN) |=> (ien == $past(wdata_i))); // R3

  AST_IEN_SET_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && addr_i == REG_IEN_SET) |=> (ien == ($past(ien) | $past(wdata_i)))); // R3

  AST_IEN_CLR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && addr_i == REG_IEN_CLR) |=> (ien == ($past(ien) & ~$past(wdata_i)))); // R3

  AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_evt != '0) |=> ((status_q & $past(edge_evt)) == $past(edge_evt))); // R9

  AST_WAKE_FROM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_o) |-> (($past(edge_evt) & $past(wake_en)) != '0)); // R6

  AST_WAKE_HAS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> (status_q != '0)); // R6

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (status_q == '0 && ien == '0 && !irq_o && !wake_o)); // R7
endmodule

bind gpio_evt_detect gpio_evt_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wdata_i(wdata_i), .we_i(we_i),
  .status_q(status_q), .ien(ien), .wake_en(wake_en), .edge_evt(edge_evt),
  .irq_o(irq_o), .wake_o(wake_o)
);

// File: tb/sim_gpio_evt_detect.sv
`timescale 1ns/1ps
module sim_gpio_evt_detect;
  localparam int NP = 32;
  localparam logic [3:0] A_STATUS = 4'd0, A_IEN = 4'd1, A_SET = 4'd2, A_CLR = 4'd3,
                         A_WAKE = 4'd4, A_LOW = 4'd5, A_HIGH = 4'd6, A_RISE = 4'd7,
                         A_FALL = 4'd8, A_DIR = 4'd9;
  localparam logic [NP-1:0] ONES = '1;

  logic clk = 1'b0;
  logic rst_n;
  logic [NP-1:0] pins, wdata, rdata;
  logic [3:0] addr;
  logic we, irq_o, wake_o;
  int total = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_evt_detect #(.NPINS(NP)) u0 (
    .clk(clk), .rst_n(rst_n), .pin_i(pins), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .rdata_o(rdata), .irq_o(irq_o), .wake_o(wake_o)
  );

  task automatic chk(input bit ok, input string req, input logic [NP-1:0] act,
                     input logic [NP-1:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [NP-1:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [NP-1:0] v);
    @(negedge clk); addr = a; we = 1'b0;
    @(negedge clk); v = rdata;
  endtask

  task automatic setpins(input logic [NP-1:0] v);
    @(negedge clk); pins = v;
    repeat (3) @(negedge clk);
  endtask

  // R1: one pin, one sense mode (0 low, 1 high, 2 rise, 3 fall)
  task automatic run_mode(input int p, input int m);
    logic pre;
    logic [NP-1:0] v, bitp;
    bitp = NP'(1) << p;
    pre  = (m == 0 || m == 3);
    wr(A_LOW, '0); wr(A_HIGH, '0); wr(A_RISE, '0); wr(A_FALL, '0);
    setpins(pre ? bitp : '0);
    wr(A_STATUS, ONES);
    wr(A_LOW + 4'(m), bitp);
    setpins(pre ? '0 : bitp);
    rd(A_STATUS, v);
    chk(v == bitp, $sformatf("R1 pin %0d mode %0d", p, m), v, bitp);
  endtask

  initial begin
    logic [NP-1:0] v;
    pins = '0; addr = '0; wdata = '0; we = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R7 reset state
    chk(irq_o == 1'b0, "R7 irq", NP'(irq_o), '0);
    chk(wake_o == 1'b0, "R7 wake", NP'(wake_o), '0);
    rd(A_STATUS, v); chk(v == '0, "R7 status", v, '0);
    rd(A_IEN, v);    chk(v == '0, "R7 ien", v, '0);
    rd(A_DIR, v);    chk(v == ONES, "R7 dir", v, ONES);

    // R10 readback
    wr(A_DIR, 32'h1234_5678); rd(A_DIR, v); chk(v == 32'h1234_5678, "R10 dir", v, 32'h1234_5678);
    wr(A_WAKE, 32'h0F0F_00FF); rd(A_WAKE, v); chk(v == 32'h0F0F_00FF, "R10 wake", v, 32'h0F0F_00FF);
    wr(A_WAKE, '0);

    // R1 sweep over every pin and sense mode
    for (int p = 0; p < NP; p++)
      for (int m = 0; m < 4; m++) run_mode(p, m);

    // R8 latency
    wr(A_LOW, '0); wr(A_HIGH, '0); wr(A_FALL, '0); wr(A_RISE, 32'h10);
    setpins('0); wr(A_STATUS, ONES); wr(A_IEN, ONES);
    @(negedge clk); pins = 32'h10;
    @(negedge clk);
    @(negedge clk); chk(irq_o == 1'b0, "R8 two edges", NP'(irq_o), '0);
    @(negedge clk); chk(irq_o == 1'b1, "R8 three edges", NP'(irq_o), 1);
    wr(A_IEN, '0);

    // R1 both edges on pin 5
    wr(A_RISE, 32'h20); wr(A_FALL, 32'h20);
    setpins('0); wr(A_STATUS, ONES);
    setpins(32'h20); rd(A_STATUS, v); chk(v == 32'h20, "R1 both rise", v, 32'h20);
    wr(A_STATUS, ONES);
    setpins('0); rd(A_STATUS, v); chk(v == 32'h20, "R1 both fall", v, 32'h20);

    // R2 write-one-to-clear
    wr(A_FALL, '0); wr(A_RISE, ONES); wr(A_STATUS, ONES);
    setpins(ONES); rd(A_STATUS, v); chk(v == ONES, "R2 all set", v, ONES);
    wr(A_STATUS, '0); rd(A_STATUS, v); chk(v == ONES, "R2 zero write", v, ONES);
    wr(A_STATUS, 32'h0000_FFFF); rd(A_STATUS, v); chk(v == 32'hFFFF_0000, "R2 half clear", v, 32'hFFFF_0000);

    // R4 interrupt gating
    wr(A_IEN, '0);          chk(irq_o == 1'b0, "R4 none", NP'(irq_o), '0);
    wr(A_IEN, 32'h0001_0000); chk(irq_o == 1'b1, "R4 hit", NP'(irq_o), 1);
    wr(A_IEN, 32'h0000_FFFF); chk(irq_o == 1'b0, "R4 miss", NP'(irq_o), '0);

    // R3 enable ports
    wr(A_IEN, 32'hA5A5_0F0F); rd(A_IEN, v); chk(v == 32'hA5A5_0F0F, "R3 direct", v, 32'hA5A5_0F0F);
    wr(A_SET, 32'h0000_F0F0); rd(A_SET, v); chk(v == 32'hA5A5_FFFF, "R3 set", v, 32'hA5A5_FFFF);
    wr(A_CLR, 32'hA500_0000); rd(A_CLR, v); chk(v == 32'h00A5_FFFF, "R3 clear", v, 32'h00A5_FFFF);
    wr(A_RISE, '0); wr(A_IEN, '0); wr(A_STATUS, ONES);

    // R5 level re-set
    wr(A_HIGH, 32'h8);
    rd(A_STATUS, v); chk(v == 32'h8, "R5 level set", v, 32'h8);
    wr(A_STATUS, 32'h8); rd(A_STATUS, v); chk(v == 32'h8, "R5 re-set", v, 32'h8);
    setpins('0);
    wr(A_STATUS, 32'h8); rd(A_STATUS, v); chk(v == '0, "R5 cleared", v, '0);

    // R6 wake from edges only
    wr(A_WAKE, ONES);
    setpins(32'h8); chk(wake_o == 1'b0, "R6 level no wake", NP'(wake_o), '0);
    wr(A_RISE, 32'h80);
    setpins(32'h88); chk(wake_o == 1'b1, "R6 edge wake", NP'(wake_o), 1);
    wr(A_STATUS, 32'h8); chk(wake_o == 1'b1, "R6 held", NP'(wake_o), 1);
    wr(A_STATUS, 32'h80); chk(wake_o == 1'b0, "R6 released", NP'(wake_o), '0);
    wr(A_HIGH, '0); wr(A_WAKE, '0);

    // R9 clear meets new edge
    wr(A_RISE, 32'h200); wr(A_STATUS, ONES);
    @(negedge clk); pins = 32'h288;
    @(negedge clk);
    @(negedge clk); addr = A_STATUS; wdata = 32'h200; we = 1'b1;
    @(negedge clk); we = 1'b0;
    rd(A_STATUS, v); chk(v == 32'h200, "R9 event wins", v, 32'h200);
    wr(A_STATUS, 32'h200); rd(A_STATUS, v); chk(v == '0, "R9 later clear", v, '0);
    rd(A_RISE, v); chk(v == 32'h200, "R10 rise", v, 32'h200);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule